// File: doc/BRIEF.md
# Serial 5B/4B Receive Aligner and Nibble Decoder

This block sits after the descrambler in a 100 Mb/s twisted-pair receive path. It accepts one descrambled code bit per clock and has no idea where the 5-bit code-group boundaries are. It waits until the line has been idle, then watches a 10-bit sliding window for the start-of-stream delimiter pair (J = 11000, then K = 10001). That pair fixes the code-group boundary for the rest of the frame. From then on, every fifth bit completes a code-group, and the block turns it into a 4-bit receive nibble with data-valid, carrier-sense and receive-error flags.

Output runs one code-group behind input, so each group can be judged together with the group after it. This lag is what lets the block recognise the two-group end delimiters: /T/ followed by /R/, or two idles in a row. A start pattern that goes wrong is reported as a bad start delimiter, with its own fixed output value. A bypass input makes the block show each raw 5-bit group on the nibble and error lines instead of decoding it.

Top module: `nib_align_dec`

## Requirements
- R1: A start-delimiter search begins only on a 0 bit that follows at least IDLE_MIN_SYMS*5 consecutive 1 bits. A 0 bit seen earlier than that is ignored: crs, rxdv and rxer stay low.
- R2: When the last bit of the 10-bit window 11000_10001 arrives (first bit received is the MSB of each group), alignment is fixed for the frame. At that same boundary rxdv rises with rxd = 0101. The next nibble is also 0101.
- R3: nib_stb pulses for one cycle at each code-group boundary in a frame, every 5 bits. The nibble presented is the one for the previous code-group. While rxdv is high, rxd changes only together with nib_stb.
- R4: Data groups decode as follows: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R5: /T/ (01101) followed by /R/ (00111) ends the frame. At the boundary that completes /R/, rxdv, crs and rxer go low. Neither symbol appears as a data nibble.
- R6: Two consecutive /I/ groups (11111) end the frame. At the boundary that completes the second /I/, rxdv and crs go low.
- R7: Any other non-data group inside a frame gives a nibble with rxer = 1 and rxdv = 1. The rxd value is then don't-care.
- R8: A /T/ not followed by /R/, or an /R/ not preceded by /T/, gives a nibble with rxer = 1.
- R9: If the 10-bit window does not match J/K, the result is a bad start delimiter: rxer = 1, rxd = 1110, rxdv = 0 and crs = 1. These values hold until EXIT_IDLE_SYMS*5 consecutive 1 bits have arrived, and then all outputs clear.
- R10: crs rises on the first 0 bit after idle, which is the third bit of J. This is seven bits before rxdv rises.
- R11: When sym_bypass is 1, each nibble carries the raw group: rxd is group bits [3:0] and rxer is group bit [4], starting with J and then K. Frame end still follows R5 and R6.
- R12: After reset, rxd = 0000 and rxdv, rxer, crs and nib_stb are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one code bit per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Descrambled serial code bit |
| sym_bypass | input | 1 | 1 = output raw 5-bit groups instead of decoded nibbles |
| rxd | output | 4 | Receive nibble |
| rxdv | output | 1 | Receive data valid |
| rxer | output | 1 | Receive error, or group bit 4 in bypass mode |
| crs | output | 1 | Carrier sense |
| nib_stb | output | 1 | One-cycle pulse when a new nibble is presented |

## Verification
The assertions check the relations between the output flags on every cycle:
- data-valid rises only with the preamble nibble, at a strobe, and after carrier sense;
- data-valid falls only together with carrier sense, at a strobe;
- strobes are never back to back;
- the nibble stays stable between strobes;
- an error without data-valid always shows 1110.

Only the bench's scenarios can show the rest:
- the decode of all sixteen data groups;
- the one-group lag;
- the difference between a lone /T/ or /R/ and a proper /T/R/ pair;
- the idle count needed to start a search and to leave the bad-delimiter state;
- the raw group values in bypass mode.

// File: rtl/nad_pkg.sv
package nad_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
    localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
    localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] NIB_PRE  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_BAD  = 4'b1110;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SSD   = 2'd1,
        ST_FRAME = 2'd2,
        ST_BAD   = 2'd3
    } nad_state_e;
endpackage

// File: rtl/nad_window.sv
// Sliding bit window plus a saturating run counter of consecutive ones.
module nad_window #(
    parameter int WIN_W   = 10,
    parameter int RUN_MAX = 10,
    localparam int RUN_W  = $clog2(RUN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win_nxt,
    output logic [RUN_W-1:0] run_q,
    output logic [RUN_W-1:0] run_nxt
);
    logic [WIN_W-1:0] win_q;

    always_comb begin
        win_nxt = {win_q[WIN_W-2:0], bit_in};
        if (!bit_in)
            run_nxt = '0;
        else if (run_q == RUN_W'(RUN_MAX))
            run_nxt = run_q;
        else
            run_nxt = run_q + RUN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            run_q <= '0;
        end else begin
            win_q <= win_nxt;
            run_q <= run_nxt;
        end
    end
endmodule

// File: rtl/nad_sym_dec.sv
// Classifies a pending code-group together with the group that follows it.
module nad_sym_dec
    import nad_pkg::*;
(
    input  logic [SYM_W-1:0] pend,
    input  logic [SYM_W-1:0] nxt,
    output logic             pend_is_data,
    output logic [NIB_W-1:0] pend_nib,
    output logic             end_pair
);
    always_comb begin
        pend_is_data = 1'b1;
        unique case (pend)
            5'b11110: pend_nib = 4'h0;
            5'b01001: pend_nib = 4'h1;
            5'b10100: pend_nib = 4'h2;
            5'b10101: pend_nib = 4'h3;
            5'b01010: pend_nib = 4'h4;
            5'b01011: pend_nib = 4'h5;
            5'b01110: pend_nib = 4'h6;
            5'b01111: pend_nib = 4'h7;
            5'b10010: pend_nib = 4'h8;
            5'b10011: pend_nib = 4'h9;
            5'b10110: pend_nib = 4'hA;
            5'b10111: pend_nib = 4'hB;
            5'b11010: pend_nib = 4'hC;
            5'b11011: pend_nib = 4'hD;
            5'b11100: pend_nib = 4'hE;
            5'b11101: pend_nib = 4'hF;
            default: begin
                pend_nib     = 4'h0;
                pend_is_data = 1'b0;
            end
        endcase
        end_pair = ((pend == SYM_T) && (nxt == SYM_R)) ||
                   ((pend == SYM_IDLE) && (nxt == SYM_IDLE));
    end
endmodule

// File: rtl/nib_align_dec.sv
module nib_align_dec
    import nad_pkg::*;
#(
    parameter int IDLE_MIN_SYMS  = 1,
    parameter int EXIT_IDLE_SYMS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             sym_bypass,
    output logic [NIB_W-1:0] rxd,
    output logic             rxdv,
    output logic             rxer,
    output logic             crs,
    output logic             nib_stb
);
    localparam int WIN_W    = 2 * SYM_W;
    localparam int IDLE_RUN = IDLE_MIN_SYMS * SYM_W;
    localparam int EXIT_RUN = EXIT_IDLE_SYMS * SYM_W;
    localparam int RUN_MAX  = (EXIT_RUN > IDLE_RUN) ? EXIT_RUN : IDLE_RUN;
    localparam int RUN_W    = $clog2(RUN_MAX + 1);
    localparam int CNT_W    = $clog2(WIN_W);
    // the first 0 of J is its third bit
    localparam int J_ZERO_POS = 3;

    typedef struct packed {
        nad_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [SYM_W-1:0] pend;
        logic             pfirst;
        logic [NIB_W-1:0] rxd;
        logic             rxdv;
        logic             rxer;
        logic             crs;
        logic             stb;
    } nad_regs_t;

    nad_regs_t r_d, r_q;

    logic [WIN_W-1:0] win_nxt;
    logic [RUN_W-1:0] run_q, run_nxt;
    logic             pend_is_data;
    logic [NIB_W-1:0] pend_nib;
    logic             end_pair;

    nad_window #(
        .WIN_W   (WIN_W),
        .RUN_MAX (RUN_MAX)
    ) window_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .win_nxt (win_nxt),
        .run_q   (run_q),
        .run_nxt (run_nxt)
    );

    nad_sym_dec dec_i (
        .pend         (r_q.pend),
        .nxt          (win_nxt[SYM_W-1:0]),
        .pend_is_data (pend_is_data),
        .pend_nib     (pend_nib),
        .end_pair     (end_pair)
    );

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;
        unique case (r_q.state)
            ST_HUNT: begin
                r_d.rxd  = '0;
                r_d.rxdv = 1'b0;
                r_d.rxer = 1'b0;
                r_d.crs  = 1'b0;
                if (!bit_in && (run_q >= RUN_W'(IDLE_RUN))) begin
                    r_d.state = ST_SSD;
                    r_d.cnt   = CNT_W'(J_ZERO_POS);
                    r_d.crs   = 1'b1;
                end
            end
            ST_SSD: begin
                if (r_q.cnt == CNT_W'(WIN_W - 1)) begin
                    r_d.cnt = '0;
                    if (win_nxt == {SYM_J, SYM_K}) begin
                        r_d.state  = ST_FRAME;
                        r_d.pend   = SYM_K;
                        r_d.pfirst = 1'b1;
                        r_d.stb    = 1'b1;
                        r_d.rxdv   = 1'b1;
                        if (sym_bypass) begin
                            r_d.rxd  = SYM_J[NIB_W-1:0];
                            r_d.rxer = SYM_J[SYM_W-1];
                        end else begin
                            r_d.rxd  = NIB_PRE;
                            r_d.rxer = 1'b0;
                        end
                    end else begin
                        r_d.state = ST_BAD;
                        r_d.rxd   = NIB_BAD;
                        r_d.rxer  = 1'b1;
                        r_d.rxdv  = 1'b0;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_FRAME: begin
                if (r_q.cnt == CNT_W'(SYM_W - 1)) begin
                    r_d.cnt    = '0;
                    r_d.stb    = 1'b1;
                    r_d.pend   = win_nxt[SYM_W-1:0];
                    r_d.pfirst = 1'b0;
                    if (end_pair) begin
                        r_d.state = ST_HUNT;
                        r_d.rxd   = '0;
                        r_d.rxdv  = 1'b0;
                        r_d.rxer  = 1'b0;
                        r_d.crs   = 1'b0;
                    end else begin
                        r_d.rxdv = 1'b1;
                        if (sym_bypass) begin
                            r_d.rxd  = r_q.pend[NIB_W-1:0];
                            r_d.rxer = r_q.pend[SYM_W-1];
                        end else if (r_q.pfirst) begin
                            r_d.rxd  = NIB_PRE;
                            r_d.rxer = 1'b0;
                        end else begin
                            r_d.rxd  = pend_nib;
                            r_d.rxer = !pend_is_data;
                        end
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_BAD: begin
                if (run_nxt >= RUN_W'(EXIT_RUN)) begin
                    r_d.state = ST_HUNT;
                    r_d.rxd   = '0;
                    r_d.rxer  = 1'b0;
                    r_d.crs   = 1'b0;
                end
            end
            default: r_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_HUNT;
            r_q.cnt    <= '0;
            r_q.pend   <= '0;
            r_q.pfirst <= 1'b0;
            r_q.rxd    <= '0;
            r_q.rxdv   <= 1'b0;
            r_q.rxer   <= 1'b0;
            r_q.crs    <= 1'b0;
            r_q.stb    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rxd     = r_q.rxd;
    assign rxdv    = r_q.rxdv;
    assign rxer    = r_q.rxer;
    assign crs     = r_q.crs;
    assign nib_stb = r_q.stb;
endmodule

// File: rtl/nad_chk.sv
module nad_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_bypass,
    input logic [3:0] rxd,
    input logic       rxdv,
    input logic       rxer,
    input logic       crs,
    input logic       nib_stb
);
    // R2: data-valid rises with a strobe and the preamble nibble
    a_r2_dv_rise_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rxdv) && !$past(sym_bypass)) |-> (nib_stb && rxd == 4'b0101));

    // R10: carrier sense is already up before data-valid rises
    a_r10_crs_leads_dv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxdv) |-> $past(crs));

    // R3: strobes are separated by at least one idle cycle
    a_r3_stb_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> !nib_stb);

    // R3: within a frame the nibble changes only at a strobe
    a_r3_rxd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rxdv && !nib_stb) |-> $stable(rxd));

    // R5: data-valid falls only at a strobe, together with carrier and error
    a_r5_dv_fall_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxdv) |-> (nib_stb && !crs && !rxer));

    // R9: an error outside a frame is the bad start delimiter value
    a_r9_bad_ssd_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rxer && !rxdv) |-> (rxd == 4'b1110 && crs));

    // R10: data-valid never stands without carrier sense
    a_r10_dv_needs_crs: assert property (@(posedge clk) disable iff (!rst_n)
        rxdv |-> crs);
endmodule

bind nib_align_dec nad_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_bypass (sym_bypass),
    .rxd        (rxd),
    .rxdv       (rxdv),
    .rxer       (rxer),
    .crs        (crs),
    .nib_stb    (nib_stb)
);

// File: tb/nib_align_dec_tb_top.sv
`timescale 1ns/1ps
module nib_align_dec_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b1;
    logic       sym_bypass = 1'b0;
    logic [3:0] rxd;
    logic       rxdv, rxer, crs, nib_stb;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nib_align_dec dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .sym_bypass (sym_bypass),
        .rxd        (rxd),
        .rxdv       (rxdv),
        .rxer       (rxer),
        .crs        (crs),
        .nib_stb    (nib_stb)
    );

    localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                           R = 5'b00111, I = 5'b11111, V = 5'b00110;

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
            4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
            4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
            4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
            4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
            4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
            4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
            4'hE: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    // packed view {stb, dv, er, crs, rxd}
    function automatic logic [7:0] outs();
        outs = {nib_stb, rxdv, rxer, crs, rxd};
    endfunction

    task automatic chk(input string req, input logic [7:0] exp, input logic [7:0] mask);
        checks++;
        if ((outs() & mask) !== (exp & mask)) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b mask=%b", req, outs(), exp, mask);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_in = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_sym(input logic [4:0] s);
        for (int i = 4; i >= 0; i--) send_bit(s[i]);
    endtask

    task automatic idles(input int n);
        for (int i = 0; i < n; i++) send_sym(I);
    endtask

    task automatic start_frame();
        idles(2);
        send_sym(J);
        send_sym(K);
        chk("R2 preamble at K", 8'b1101_0101, 8'hFF);
    endtask

    task automatic t_reset();
        chk("R12 reset state", 8'h00, 8'hFF);
    endtask

    task automatic t_no_idle();
        logic [9:0] pat = {J, K};
        for (int i = 9; i >= 0; i--) begin
            send_bit(pat[i]);
            chk("R1 zero before idle ignored", 8'h00, 8'hFF);
        end
    endtask

    task automatic t_normal();
        idles(2);
        send_bit(1'b1); send_bit(1'b1);
        chk("R10 crs low during leading ones", 8'h00, 8'hFF);
        send_bit(1'b0);
        chk("R10 crs on first zero", 8'b0001_0000, 8'hFF);
        send_bit(1'b0); send_bit(1'b0);
        send_sym(K);
        chk("R2 preamble at K", 8'b1101_0101, 8'hFF);
        for (int d = 0; d < 16; d++) begin
            logic [4:0] s = enc(4'(d));
            if (d == 0) begin
                for (int i = 4; i >= 1; i--) send_bit(s[i]);
                chk("R3 nibble held between boundaries", 8'b0101_0101, 8'hFF);
                send_bit(s[0]);
                chk("R2 second preamble nibble", 8'b1101_0101, 8'hFF);
            end else begin
                send_sym(s);
                chk("R4 data decode", {4'b1101, 4'(d - 1)}, 8'hFF);
            end
        end
        send_sym(T);
        chk("R4 last data before T", 8'b1101_1111, 8'hFF);
        send_sym(R);
        chk("R5 T/R ends frame", 8'b1000_0000, 8'hFF);
        send_bit(1'b1);
        chk("R5 quiet after end", 8'h00, 8'hFF);
    endtask

    task automatic t_idle_end();
        start_frame();
        send_sym(enc(4'h9));
        send_sym(enc(4'hA));
        chk("R4 data 9", 8'b1101_1001, 8'hFF);
        send_sym(I);
        chk("R6 data before first idle", 8'b1101_1010, 8'hFF);
        send_sym(I);
        chk("R6 two idles end frame", 8'b1000_0000, 8'hFF);
    endtask

    task automatic t_invalid();
        start_frame();
        send_sym(enc(4'h3));
        send_sym(V);
        chk("R4 data 3", 8'b1101_0011, 8'hFF);
        send_sym(enc(4'h4));
        chk("R7 invalid group flags error", 8'b1111_0000, 8'hF0);
        send_sym(T);
        chk("R7 error clears on next data", 8'b1101_0100, 8'hFF);
        send_sym(R);
        chk("R5 end after error", 8'b1000_0000, 8'hFF);
    endtask

    task automatic t_lone_t();
        start_frame();
        send_sym(enc(4'h1));
        send_sym(T);
        send_sym(enc(4'h2));
        chk("R8 lone T flags error", 8'b1111_0000, 8'hF0);
        send_sym(enc(4'h3));
        chk("R8 data after lone T", 8'b1101_0010, 8'hFF);
        send_sym(T);
        send_sym(R);
        chk("R5 end after lone T", 8'b1000_0000, 8'hFF);
    endtask

    task automatic t_lone_r();
        start_frame();
        send_sym(enc(4'h1));
        send_sym(R);
        chk("R8 data before lone R", 8'b1101_0001, 8'hFF);
        send_sym(enc(4'h2));
        chk("R8 lone R flags error", 8'b1111_0000, 8'hF0);
        send_sym(T);
        send_sym(R);
        chk("R5 end after lone R", 8'b1000_0000, 8'hFF);
    endtask

    task automatic t_bad_ssd();
        idles(2);
        send_sym(J);
        send_sym(5'b10100);
        chk("R9 bad start delimiter", 8'b0011_1110, 8'hFF);
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        chk("R9 bad state held", 8'b0011_1110, 8'hFF);
        send_bit(1'b1);
        chk("R9 cleared after two idles", 8'h00, 8'hFF);
    endtask

    task automatic t_bypass();
        sym_bypass = 1'b1;
        idles(2);
        send_sym(J);
        send_sym(K);
        chk("R11 raw J", 8'b1111_1000, 8'hFF);
        send_sym(enc(4'h6));
        chk("R11 raw K", 8'b1111_0001, 8'hFF);
        send_sym(T);
        chk("R11 raw data group", 8'b1101_1110, 8'hFF);
        send_sym(R);
        chk("R11 end in bypass", 8'b1000_0000, 8'hFF);
        sym_bypass = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bit_in = 1'b1;
        t_no_idle();
        t_normal();
        t_idle_end();
        t_invalid();
        t_lone_t();
        t_lone_r();
        t_bad_ssd();
        t_bypass();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule